// File: doc/BRIEF.md
# Colour Lookup Table with Auto-Increment Loader

This block holds a 256-entry colour lookup table for a display pipeline. The entries are loaded through one 32-bit register-write port. The top bits of each written word select a target register, and the low bits carry the data for it. Software first writes the table-index register to place an internal write pointer. After that, each table-data write stores one 24-bit colour at the pointer and moves the pointer on by one. A whole palette therefore loads as one index write followed by a stream of data writes. The pointer wraps from the last entry back to the first.

A border colour register and three cursor colour registers sit beside the table and are written through the same port. When all three cursor colours are zero, the block reports that the cursor is blanked. The pixel side presents an 8-bit index and receives the stored 24-bit colour one clock later. A write to a register code that the block does not know changes nothing and raises an error flag for one cycle.

Top module: `colour_lut`

## Requirements
- R1: A synchronous active-low reset clears the write pointer, every table entry, the border and cursor colours, the pixel output and the error flag to zero.
- R2: The register code is bits [31:28] of the written word. Bits [27:24] are ignored. A colour is bits [23:0], with red in [7:0], green in [15:8] and blue in [23:16].
- R3: A write with code 0x1 loads the write pointer from bits [7:0] of the word.
- R4: A write with code 0x0 stores the colour in the table entry at the write pointer, then adds one to the pointer.
- R5: The write pointer is 8 bits wide and moves from 255 to 0.
- R6: Code 0x4 writes the border colour. Codes 0x5, 0x6 and 0x7 write cursor colours 1, 2 and 3, which appear on `cursor_rgb` at bits [23:0], [47:24] and [71:48].
- R7: `cursor_blank` is high exactly when all three cursor colours are zero.
- R8: A write with any other code changes no pointer, table entry or colour register, and sets `wr_err` high in the following cycle.
- R9: `pix_rgb` shows the entry selected by `pix_idx` one cycle after the index is presented. If a write to the same entry happens in that same cycle, `pix_rgb` shows the old value, and the new value appears from the next cycle.
- R10: `wr_err` is low in any cycle that follows a recognised write or no write at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_word | input | 32 | Register code in the top bits, data below |
| wr_err | output | 1 | Set for one cycle after a write with an unknown code |
| pix_idx | input | 8 | Pixel colour index |
| pix_rgb | output | 24 | Looked-up colour, registered |
| border_rgb | output | 24 | Border colour |
| cursor_rgb | output | 72 | Cursor colours 1 to 3, with cursor 1 in the low slot |
| cursor_blank | output | 1 | High when all cursor colours are zero |

## Verification
A wrong write pointer is not visible on any port directly. It shows up only when the bench reads back through `pix_idx`, as a colour that landed one entry off or in an entry that should have stayed zero. The bench therefore reads the table back after an index write, after a wrap past entry 255, and after a write with an unknown code. A stale or mis-decoded border or cursor register shows on its output in the cycle after the write. A read-during-write hazard shows as the new colour arriving one cycle too early.

// File: rtl/colour_lut_pkg.sv
// Package: register codes and field widths shared by the colour lookup block.
// Assumes the register code occupies the top LUT_CODE_W bits of a write word.
package colour_lut_pkg;

    localparam int unsigned LUT_CODE_W = 4;

    // Register codes; cursor registers follow LUT_CURSOR_BASE consecutively.
    localparam logic [LUT_CODE_W-1:0] LUT_PAL_DATA    = 4'h0;
    localparam logic [LUT_CODE_W-1:0] LUT_PAL_INDEX   = 4'h1;
    localparam logic [LUT_CODE_W-1:0] LUT_BORDER      = 4'h4;
    localparam logic [LUT_CODE_W-1:0] LUT_CURSOR_BASE = 4'h5;

    // Decoded write strobes for one bus write.
    typedef struct packed {
        logic data_we;
        logic index_we;
        logic border_we;
    } lut_strobe_t;

endpackage

// File: rtl/colour_lut_decode.sv
// Module: decodes the register code of a write into one-hot strobes and
// registers an error flag for codes it does not recognise.
// Assumes at most one write per cycle; CUR_N cursor codes follow the base code.
module colour_lut_decode
    import colour_lut_pkg::*;
#(
    parameter int unsigned CUR_N = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [LUT_CODE_W-1:0] code,
    output lut_strobe_t           strobe,
    output logic [CUR_N-1:0]      cur_we,
    output logic                  wr_err
);

    logic bad_code;

    // Purpose: map the register code to exactly one strobe or to an error.
    always_comb begin
        strobe   = '0;
        cur_we   = '0;
        bad_code = 1'b0;
        if (wr_en) begin
            if (code == LUT_PAL_DATA) begin
                strobe.data_we = 1'b1;
            end else if (code == LUT_PAL_INDEX) begin
                strobe.index_we = 1'b1;
            end else if (code == LUT_BORDER) begin
                strobe.border_we = 1'b1;
            end else begin
                bad_code = 1'b1;
                for (int i = 0; i < int'(CUR_N); i++) begin
                    if (int'(code) == int'(LUT_CURSOR_BASE) + i) begin
                        cur_we[i] = 1'b1;
                        bad_code  = 1'b0;
                    end
                end
            end
        end
    end

    // Purpose: hold the error flag for the cycle after a rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= bad_code;
        end
    end

endmodule

// File: rtl/colour_lut_ptr.sv
// Module: self-incrementing table write pointer.
// Assumes set and step are never asserted together; wraps modulo 2**IDX_W.
module colour_lut_ptr #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic [IDX_W-1:0] set_val,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);

    // Purpose: load on an index write, advance after each data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (set) begin
            ptr <= set_val;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/colour_lut_ram.sv
// Module: colour table storage with one write port and one pixel read port.
// Assumes the read returns the pre-write value when both hit one entry in a
// cycle; READ_REG selects a registered (1) or combinational (0) read.
module colour_lut_ram #(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned RGB_W    = 24,
    parameter bit          READ_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [RGB_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [RGB_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [RGB_W-1:0] mem [DEPTH];

    // Purpose: clear all entries on reset, otherwise store one colour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    generate
        if (READ_REG) begin : g_rd_reg
            // Purpose: one register stage on the pixel lookup.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rdata <= '0;
                end else begin
                    rdata <= mem[raddr];
                end
            end
        end else begin : g_rd_comb
            assign rdata = mem[raddr];
        end
    endgenerate

endmodule

// File: rtl/colour_lut_side.sv
// Module: border colour and cursor colour registers next to the table.
// Assumes write strobes come from the decoder, at most one per cycle.
module colour_lut_side #(
    parameter int unsigned RGB_W = 24,
    parameter int unsigned CUR_N = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   border_we,
    input  logic [CUR_N-1:0]       cur_we,
    input  logic [RGB_W-1:0]       wdata,
    output logic [RGB_W-1:0]       border_rgb,
    output logic [CUR_N*RGB_W-1:0] cursor_rgb
);

    // Purpose: hold the border colour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            border_rgb <= '0;
        end else if (border_we) begin
            border_rgb <= wdata;
        end
    end

    for (genvar c = 0; c < int'(CUR_N); c++) begin : g_cursor
        // Purpose: hold one cursor colour in its slot of the flat output.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cursor_rgb[c*RGB_W +: RGB_W] <= '0;
            end else if (cur_we[c]) begin
                cursor_rgb[c*RGB_W +: RGB_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/colour_lut.sv
// Module: top of the colour lookup block. It splits each bus write into a
// code and a payload, drives the pointer, table and side registers, and
// flags a blanked cursor.
// Assumes WORD_W - LUT_CODE_W > RGB_W and RGB_W >= IDX_W.
module colour_lut
    import colour_lut_pkg::*;
#(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned CH_W     = 8,
    parameter int unsigned CUR_N    = 3,
    parameter bit          READ_REG = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [WORD_W-1:0]             wr_word,
    output logic                          wr_err,
    input  logic [IDX_W-1:0]              pix_idx,
    output logic [3*CH_W-1:0]             pix_rgb,
    output logic [3*CH_W-1:0]             border_rgb,
    output logic [CUR_N*3*CH_W-1:0]       cursor_rgb,
    output logic                          cursor_blank
);

    localparam int unsigned RGB_W = 3 * CH_W;

    logic [LUT_CODE_W-1:0] code;
    logic [RGB_W-1:0]      colour;
    logic [IDX_W-1:0]      index_val;
    logic                  unused_bits;
    lut_strobe_t           strobe;
    logic [CUR_N-1:0]      cur_we;
    logic [IDX_W-1:0]      wr_ptr;

    assign code        = wr_word[WORD_W-1 -: LUT_CODE_W];
    assign colour      = wr_word[RGB_W-1:0];
    assign index_val   = wr_word[IDX_W-1:0];
    assign unused_bits = ^wr_word[WORD_W-LUT_CODE_W-1:RGB_W];

    colour_lut_decode #(.CUR_N(CUR_N)) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .code   (code),
        .strobe (strobe),
        .cur_we (cur_we),
        .wr_err (wr_err)
    );

    colour_lut_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (strobe.index_we),
        .set_val (index_val),
        .step    (strobe.data_we),
        .ptr     (wr_ptr)
    );

    colour_lut_ram #(.IDX_W(IDX_W), .RGB_W(RGB_W), .READ_REG(READ_REG)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (strobe.data_we),
        .waddr (wr_ptr),
        .wdata (colour),
        .raddr (pix_idx),
        .rdata (pix_rgb)
    );

    colour_lut_side #(.RGB_W(RGB_W), .CUR_N(CUR_N)) u_side (
        .clk        (clk),
        .rst_n      (rst_n),
        .border_we  (strobe.border_we),
        .cur_we     (cur_we),
        .wdata      (colour),
        .border_rgb (border_rgb),
        .cursor_rgb (cursor_rgb)
    );

    // Purpose: report a blanked cursor when every cursor colour is zero.
    assign cursor_blank = ~|cursor_rgb;

endmodule

// File: rtl/colour_lut_chk.sv
// Module: assertion checker bound to colour_lut; observes ports and the
// internal write pointer.
module colour_lut_chk
    import colour_lut_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned RGB_W  = 24,
    parameter int unsigned CUR_N  = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [WORD_W-1:0]      wr_word,
    input logic                   wr_err,
    input logic [IDX_W-1:0]       ptr,
    input logic [RGB_W-1:0]       border_rgb,
    input logic [CUR_N*RGB_W-1:0] cursor_rgb,
    input logic                   cursor_blank
);

    logic [LUT_CODE_W-1:0] code;
    logic                  is_cur;
    logic                  known;

    assign code   = wr_word[WORD_W-1 -: LUT_CODE_W];
    assign is_cur = (int'(code) >= int'(LUT_CURSOR_BASE)) &&
                    (int'(code) <  int'(LUT_CURSOR_BASE) + int'(CUR_N));
    assign known  = (code == LUT_PAL_DATA) || (code == LUT_PAL_INDEX) ||
                    (code == LUT_BORDER) || is_cur;

    // R1: reset leaves the pointer and border colour cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (ptr == '0) && (border_rgb == '0) && !wr_err);

    // R3: index write loads the pointer
    p_ptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && code == LUT_PAL_INDEX) |=> ptr == $past(wr_word[IDX_W-1:0]));

    // R4, R5: data write advances the pointer by one, modulo the table size
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && code == LUT_PAL_DATA) |=> ptr == IDX_W'($past(ptr) + 1'b1));

    // R7: a non-zero cursor colour write removes the blank state
    p_blank_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_cur && wr_word[RGB_W-1:0] != '0) |=> !cursor_blank);

    // R8: rejected write leaves state alone and flags an error
    p_bad_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !known) |=> wr_err && $stable(ptr) && $stable(border_rgb)
                              && $stable(cursor_rgb));

    // R10: the error flag only follows a rejected write
    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> ($past(wr_en) && !$past(known)));

endmodule

bind colour_lut colour_lut_chk #(
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W),
    .RGB_W  (3 * CH_W),
    .CUR_N  (CUR_N)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_word      (wr_word),
    .wr_err       (wr_err),
    .ptr          (wr_ptr),
    .border_rgb   (border_rgb),
    .cursor_rgb   (cursor_rgb),
    .cursor_blank (cursor_blank)
);

// File: tb/tb_colour_lut.sv
module tb_colour_lut;

    localparam int CLK_P = 10;
    localparam int NVEC  = 12;

    // Vector: {expected wr_err, written word}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 32'h1000_00FA},   // index = 250
        {1'b0, 32'h0012_3456},   // entry 250
        {1'b0, 32'h0065_4321},   // entry 251
        {1'b0, 32'h00FF_0000},   // entry 252 (blue only)
        {1'b0, 32'h0000_FF00},   // entry 253
        {1'b0, 32'h0000_00FF},   // entry 254
        {1'b0, 32'h00AB_CDEF},   // entry 255
        {1'b0, 32'h0001_0203},   // wraps to entry 0
        {1'b1, 32'h9000_0777},   // unknown code
        {1'b0, 32'h0F80_8080},   // entry 1, bits 27:24 ignored
        {1'b0, 32'h4033_2211},   // border
        {1'b0, 32'h5000_0001}    // cursor 1
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_word;
    logic        wr_err;
    logic [7:0]  pix_idx;
    logic [23:0] pix_rgb;
    logic [23:0] border_rgb;
    logic [71:0] cursor_rgb;
    logic        cursor_blank;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [23:0] mem_m [256];
    logic [7:0]  ptr_m;
    logic [23:0] border_m;
    logic [23:0] cur_m [3];

    always #(CLK_P/2) clk = ~clk;

    colour_lut dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_word      (wr_word),
        .wr_err       (wr_err),
        .pix_idx      (pix_idx),
        .pix_rgb      (pix_rgb),
        .border_rgb   (border_rgb),
        .cursor_rgb   (cursor_rgb),
        .cursor_blank (cursor_blank)
    );

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 256; i++) mem_m[i] = '0;
        ptr_m = '0; border_m = '0;
        for (int i = 0; i < 3; i++) cur_m[i] = '0;
    endtask

    // Model from the requirements; returns the expected error flag
    task automatic model_write(input logic [31:0] w, output bit err);
        err = 1'b0;
        case (w[31:28])
            4'h0: begin mem_m[ptr_m] = w[23:0]; ptr_m = ptr_m + 8'd1; end
            4'h1: ptr_m = w[7:0];
            4'h4: border_m = w[23:0];
            4'h5: cur_m[0] = w[23:0];
            4'h6: cur_m[1] = w[23:0];
            4'h7: cur_m[2] = w[23:0];
            default: err = 1'b1;
        endcase
    endtask

    // Called at a negedge; returns at the negedge after the capturing edge
    task automatic do_write(input logic [31:0] w, output bit err);
        model_write(w, err);
        wr_en = 1'b1; wr_word = w;
        @(negedge clk);
        wr_en = 1'b0; wr_word = '0;
    endtask

    task automatic read_pix(input logic [7:0] idx, output logic [23:0] v);
        pix_idx = idx;
        @(negedge clk);
        v = pix_rgb;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bit          e;
        logic [23:0] v;
        rst_n = 1'b0; wr_en = 1'b0; wr_word = '0; pix_idx = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 wr_err", wr_err, 0);
        chk("R1 border", border_rgb, 0);
        chk("R1 cursor", cursor_rgb, 0);
        chk("R7 blank after reset", cursor_blank, 1);
        read_pix(8'd0, v);   chk("R1 entry0", v, 0);
        read_pix(8'd255, v); chk("R1 entry255", v, 0);

        // Vector walk: load across the wrap, one unknown code, side registers
        for (int k = 0; k < NVEC; k++) begin
            do_write(VEC[k][31:0], e);
            chk(VEC[k][32] ? "R8 err flag" : "R10 err low", wr_err, VEC[k][32]);
            chk("R8 expected err matches table", e, VEC[k][32]);
        end
        for (int i = 250; i < 258; i++) begin
            read_pix(8'(i), v);
            chk((i > 255) ? "R5 wrap entry" : "R4 loaded entry", v, mem_m[8'(i)]);
        end
        read_pix(8'd252, v); chk("R2 blue in [23:16]", v[23:16], 8'hFF);
        read_pix(8'd1, v);   chk("R2 bits 27:24 ignored", v, 24'h808080);
        chk("R6 border", border_rgb, 24'h332211);
        chk("R6 cursor slots", cursor_rgb, {cur_m[2], cur_m[1], cur_m[0]});
        chk("R7 not blank", cursor_blank, 0);

        // R3: index write positions the pointer
        do_write(32'h1000_0010, e);
        do_write(32'h0000_0777, e);
        read_pix(8'd16, v); chk("R3 entry16", v, 24'h000777);
        read_pix(8'd17, v); chk("R3 entry17 untouched", v, 24'h000000);

        // R8: unknown code has no effect on pointer or registers
        do_write(32'hF000_0055, e);
        chk("R8 err set", wr_err, 1);
        chk("R8 border kept", border_rgb, 24'h332211);
        chk("R8 cursor kept", cursor_rgb, {cur_m[2], cur_m[1], cur_m[0]});
        @(negedge clk);
        chk("R10 err clears", wr_err, 0);
        do_write(32'h0000_0999, e);
        read_pix(8'd17, v); chk("R8 pointer kept", v, 24'h000999);

        // R9: same-cycle write and read of one entry returns old value first
        do_write(32'h1000_0005, e);
        pix_idx = 8'd5;
        do_write(32'h0000_5A5A, e);
        chk("R9 old value", pix_rgb, 24'h000000);
        @(negedge clk);
        chk("R9 new value", pix_rgb, 24'h005A5A);

        // R7: blank tracks all cursor colours
        do_write(32'h5000_0000, e);
        chk("R7 blank all zero", cursor_blank, 1);
        do_write(32'h6000_0100, e);
        chk("R7 cursor2 unblanks", cursor_blank, 0);
        chk("R6 cursor2 slot", cursor_rgb[47:24], 24'h000100);
        do_write(32'h6000_0000, e);
        chk("R7 blank again", cursor_blank, 1);

        // R1: reset mid-run clears everything and the pointer
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        chk("R1 border cleared", border_rgb, 0);
        do_write(32'h0000_0123, e);
        read_pix(8'd0, v);   chk("R1 pointer cleared", v, 24'h000123);
        read_pix(8'd250, v); chk("R1 table cleared", v, 24'h000000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule